// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit of a small 8-bit processor. It accepts a fetched opcode byte, then walks that instruction through a short series of steps. On each step it presents a 24-bit control word, which it reads from a microcode store that can be rewritten at run time. The store is indexed by the upper six opcode bits and the current step number. The lower two opcode bits pick one of four condition flags. Two bits in the control word let an instruction end at a chosen step, or end early when a selected condition is false. This is how a conditional relative jump spends four or five cycles, and how a pointer increment spends a third cycle only when the low byte carries into the high byte.

Opcodes enter over a valid/ready stream. The producer raises `op_valid` and holds `opcode` stable until a cycle in which `op_ready` is also high, which is the cycle the opcode is taken. `op_ready` stays low while an instruction is running and after a halt, so the producer is held off. The `step_adv` input is plain control. The datapath drives it low to freeze the current step, for example while a slow output port finishes. A halt opcode stops the block until reset.

Top module: `useq_sequencer`

## Requirements
- R1: Right after reset, `op_ready` is 1, `ctrl_word` is 0 and `instr_done` is 0.
- R2: An opcode is taken on a clock edge where `op_valid` and `op_ready` are both 1. From that edge until one cycle after `instr_done`, `op_ready` is 0.
- R3: While an instruction runs, `ctrl_word` equals the store entry at address {opcode[7:2], step}, where `step` is 3 bits. The step is 0 in the first cycle after the opcode is taken.
- R4: The step moves forward only on an edge where `step_adv` is 1. In any cycle with `step_adv` at 0, the step and `ctrl_word` stay the same.
- R5: When control bit 23 (last step) is set and `step_adv` is 1, `instr_done` is 1 in that cycle and the instruction ends. In the next cycle the block is idle and `op_ready` is 1.
- R6: When control bit 22 (end if false) is set and `step_adv` is 1, the instruction ends in that cycle if the selected condition is false. The condition is `cond_flags[opcode[1:0]]`, with bit 0 = zero, 1 = carry, 2 = negative, 3 = overflow. If the condition is true, the sequence carries on to the next step.
- R7: For the inverted-branch instruction, whose opcode[7:2] = 33, the selected flag is negated before the R6 test.
- R8: When control bit 21 is set, the R6 test uses `addr_carry` instead of a flag.
- R9: No instruction lasts more than 6 steps. Advancing out of step 5 always ends the instruction, with `instr_done` high.
- R10: After the halt instruction, opcode[7:2] = 40, is taken, three things hold until reset: `op_ready` is 0, `ctrl_word` is 0 and `instr_done` is 0.
- R11: A store write with `uc_we` = 1 replaces one byte of the entry at `uc_addr`: lane 0 writes bits 7:0, lane 1 writes bits 15:8 and lane 2 writes bits 23:16. Lane 3 writes nothing, and the other bytes of the entry are kept.
- R12: While idle (no instruction running), `ctrl_word` is 0 and `instr_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode stream valid |
| op_ready | output | 1 | Opcode stream ready |
| opcode | input | 8 | Fetched opcode byte |
| step_adv | input | 1 | Advance the current step on this edge |
| cond_flags | input | 4 | Flags: 0 zero, 1 carry, 2 negative, 3 overflow |
| addr_carry | input | 1 | Carry or borrow from the low address byte |
| uc_we | input | 1 | Microcode byte write enable |
| uc_addr | input | 9 | Microcode entry address {op[7:2], step} |
| uc_lane | input | 2 | Byte lane of the write |
| uc_data | input | 8 | Write byte |
| ctrl_word | output | 24 | Control word of the current step |
| instr_done | output | 1 | One-cycle pulse on the final step |

## Verification
The bench runs conditional branches with the chosen condition both true and false, and with the inverted-branch opcode. A design that tests the wrong flag, or skips the inversion, ends the jump one cycle early or one cycle late. The pointer-increment pattern runs with and without `addr_carry`, which catches a design that reads the flag there instead of the carry. An output instruction has stall cycles inserted on every step; a sequencer that advances on its own would show the next step's word too soon. The bench also checks four more behaviours, each of which a faulty design would visibly break:
- A microcode run that never sets the last-step bit must still stop at step 5; a faulty design would wrap or run on.
- Lane 3 writes and single-lane writes must leave the other bytes alone; a faulty design would corrupt them.
- After a halt, a waiting `op_valid` must be refused; a faulty design would accept it.
- After a halt, `ctrl_word` must stay 0; a faulty design would leak a control word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CW_W      = 24;
  localparam int OPF_W     = 6;
  localparam int STEP_W    = 3;
  localparam int NFLAGS    = 4;
  localparam int BIT_LAST  = 23;
  localparam int BIT_CFIN  = 22;
  localparam int BIT_CSRC  = 21;
  localparam logic [OPF_W-1:0] OP_NEG_BR = 6'd33;
  localparam logic [OPF_W-1:0] OP_HALT   = 6'd40;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HALT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW    = 9,
  parameter int LANES = 3,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    lane,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (lane == 2'(l))) bank[waddr] <= wdata;
    end
    assign rdata[l*8 +: 8] = bank[raddr];
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond #(
  parameter int NF = 4,
  localparam int SW = $clog2(NF)
) (
  input  logic [NF-1:0] flags,
  input  logic [SW-1:0] sel,
  input  logic          invert,
  input  logic          use_carry,
  input  logic          carry,
  output logic          cond
);
  logic picked;
  always_comb begin
    picked = flags[sel] ^ invert;
    cond   = use_carry ? carry : picked;
  end
endmodule

// File: rtl/useq_stepper.sv
module useq_stepper
  import useq_pkg::*;
#(
  parameter int MAX_STEPS = 6,
  parameter int OPW = 8,
  localparam int SW = STEP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] opcode,
  input  logic           adv,
  input  logic           w_last,
  input  logic           w_cfin,
  input  logic           cond,
  output logic           op_ready,
  output logic           active,
  output logic           halted,
  output logic [SW-1:0]  step,
  output logic [OPW-1:0] ir,
  output logic           done
);
  localparam logic [SW-1:0] STEP_TOP = SW'(MAX_STEPS - 1);

  sq_state_e st_q;
  logic      finish;
  logic      take;

  assign active   = (st_q == SQ_RUN);
  assign halted   = (st_q == SQ_HALT);
  assign op_ready = (st_q == SQ_IDLE);
  assign take     = op_ready && op_valid;
  assign finish   = w_last || (w_cfin && !cond) || (step == STEP_TOP);
  assign done     = active && adv && finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      step <= '0;
      ir   <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (take) begin
          ir   <= opcode;
          step <= '0;
          st_q <= (opcode[OPW-1 -: OPF_W] == OP_HALT) ? SQ_HALT : SQ_RUN;
        end
        SQ_RUN: if (adv) begin
          if (finish) begin
            step <= '0;
            st_q <= SQ_IDLE;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: st_q <= SQ_HALT;
      endcase
    end
  end

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !op_ready);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv) |=> (active && $stable(step)));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (op_ready && step == '0));
  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_TOP);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !op_ready));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int MAX_STEPS = 6,
  localparam int AW = OPF_W + STEP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [7:0]      opcode,
  input  logic            step_adv,
  input  logic [3:0]      cond_flags,
  input  logic            addr_carry,
  input  logic            uc_we,
  input  logic [AW-1:0]   uc_addr,
  input  logic [1:0]      uc_lane,
  input  logic [7:0]      uc_data,
  output logic [CW_W-1:0] ctrl_word,
  output logic            instr_done
);
  logic [CW_W-1:0]  rd_word;
  logic [STEP_W-1:0] step;
  logic [7:0]       ir;
  logic             active, halted, cond;

  useq_store #(.AW(AW), .LANES(CW_W / 8)) store_i (
    .clk   (clk),
    .we    (uc_we),
    .waddr (uc_addr),
    .lane  (uc_lane),
    .wdata (uc_data),
    .raddr ({ir[7:2], step}),
    .rdata (rd_word)
  );

  useq_cond #(.NF(NFLAGS)) cond_i (
    .flags     (cond_flags),
    .sel       (ir[1:0]),
    .invert    (ir[7:2] == OP_NEG_BR),
    .use_carry (rd_word[BIT_CSRC]),
    .carry     (addr_carry),
    .cond      (cond)
  );

  useq_stepper #(.MAX_STEPS(MAX_STEPS), .OPW(8)) step_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .opcode   (opcode),
    .adv      (step_adv),
    .w_last   (rd_word[BIT_LAST]),
    .w_cfin   (rd_word[BIT_CFIN]),
    .cond     (cond),
    .op_ready (op_ready),
    .active   (active),
    .halted   (halted),
    .step     (step),
    .ir       (ir),
    .done     (instr_done)
  );

  assign ctrl_word = active ? rd_word : '0;

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (ctrl_word == '0 && !instr_done));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (ctrl_word == '0 && !instr_done));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  opcode = '0;
  logic        step_adv = 1'b0;
  logic [3:0]  cond_flags = '0;
  logic        addr_carry = 1'b0;
  logic        uc_we = 1'b0;
  logic [8:0]  uc_addr = '0;
  logic [1:0]  uc_lane = '0;
  logic [7:0]  uc_data = '0;
  logic [23:0] ctrl_word;
  logic        instr_done;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct packed { logic [23:0] cw; logic dn; logic rd; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  logic [23:0] mc [512];

  always #10 clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .opcode(opcode), .step_adv(step_adv), .cond_flags(cond_flags),
    .addr_carry(addr_carry), .uc_we(uc_we), .uc_addr(uc_addr),
    .uc_lane(uc_lane), .uc_data(uc_data), .ctrl_word(ctrl_word),
    .instr_done(instr_done)
  );

  task automatic push(input logic [23:0] cw, input logic dn, input logic rd, input string tag);
    item_t it;
    it.cw = cw; it.dn = dn; it.rd = rd;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // monitor: compares one expected item per cycle, mid-low-phase
  always @(negedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ctrl_word !== e.cw || instr_done !== e.dn || op_ready !== e.rd) begin
        errors++;
        $display("FAIL %s: got cw=%h done=%b rdy=%b expected cw=%h done=%b rdy=%b",
                 t, ctrl_word, instr_done, op_ready, e.cw, e.dn, e.rd);
      end
    end
  end

  task automatic wr_byte(input logic [8:0] a, input logic [1:0] ln, input logic [7:0] d);
    @(negedge clk);
    uc_we = 1'b1; uc_addr = a; uc_lane = ln; uc_data = d;
    @(negedge clk);
    uc_we = 1'b0;
    if (ln != 2'd3) mc[a][ln*8 +: 8] = d;
  endtask

  task automatic load(input logic [5:0] op, input int s, input logic [2:0] ctl);
    logic [8:0] a;
    logic [23:0] w;
    a = {op, 3'(s)};
    w = {ctl, 21'(32'h1A5A5 + op * 77 + s * 13)};
    for (int l = 0; l < 3; l++) wr_byte(a, 2'(l), w[l*8 +: 8]);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [3:0] fl, input logic cy,
                        input int stall, input string tag);
    int st;
    logic [23:0] w;
    logic cnd, fin;
    st = 0;
    @(negedge clk);
    cond_flags = fl; addr_carry = cy; opcode = op; op_valid = 1'b1; step_adv = 1'b0;
    push(24'h0, 1'b0, 1'b1, tag);   // R2: ready while idle
    @(negedge clk);
    op_valid = 1'b0;
    forever begin
      w = mc[{op[7:2], 3'(st)}];
      for (int k = 0; k < stall; k++) begin
        step_adv = 1'b0;
        push(w, 1'b0, 1'b0, tag);  // R4: held
        @(negedge clk);
      end
      step_adv = 1'b1;
      cnd = w[21] ? cy : (fl[op[1:0]] ^ (op[7:2] == 6'd33));
      fin = w[23] || (w[22] && !cnd) || (st == 5);
      push(w, fin, 1'b0, tag);
      @(negedge clk);
      step_adv = 1'b0;
      if (fin) break;
      st++;
    end
    push(24'h0, 1'b0, 1'b1, tag);   // R12: idle again
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(24'h0, 1'b0, 1'b1, "R1 reset");

    load(6'd9, 0, 3'b100);                      // single-step
    for (int s = 0; s < 3; s++) load(6'd35, s, (s == 2) ? 3'b100 : 3'b000);
    for (int s = 0; s < 5; s++) begin
      load(6'd32, s, (s == 4) ? 3'b100 : (s == 3) ? 3'b010 : 3'b000);
      load(6'd33, s, (s == 4) ? 3'b100 : (s == 3) ? 3'b010 : 3'b000);
    end
    for (int s = 0; s < 3; s++) load(6'd11, s, (s == 2) ? 3'b100 : (s == 1) ? 3'b011 : 3'b000);
    for (int s = 0; s < 6; s++) load(6'd2, s, 3'b000);
    load(6'd14, 0, 3'b100);

    run_op(8'h24, 4'h0, 1'b0, 0, "R3/R5 single");
    run_op(8'h8D, 4'h0, 1'b0, 2, "R4 stall");
    run_op(8'h80, 4'b0001, 1'b0, 0, "R6 z true");
    run_op(8'h80, 4'b1110, 1'b0, 0, "R6 z false");
    run_op(8'h81, 4'b0010, 1'b0, 1, "R6 c true");
    run_op(8'h84, 4'b0001, 1'b0, 0, "R7 inv z");
    run_op(8'h87, 4'b0000, 1'b0, 0, "R7 inv v");
    run_op(8'h2C, 4'hF, 1'b0, 0, "R8 no carry");
    run_op(8'h2C, 4'h0, 1'b1, 0, "R8 carry");
    run_op(8'h08, 4'h0, 1'b0, 0, "R9 cap");

    wr_byte({6'd14, 3'd0}, 2'd3, 8'hFF);
    run_op(8'h38, 4'h0, 1'b0, 0, "R11 lane3");
    wr_byte({6'd14, 3'd0}, 2'd1, 8'h00);
    run_op(8'h38, 4'h0, 1'b0, 0, "R11 lane1");

    // R10: halt then a refused opcode
    @(negedge clk);
    opcode = 8'hA0; op_valid = 1'b1; step_adv = 1'b1;
    push(24'h0, 1'b0, 1'b1, "R10 halt take");
    @(negedge clk);
    opcode = 8'h24;
    for (int k = 0; k < 4; k++) begin
      push(24'h0, 1'b0, 1'b0, "R10 halted");
      @(negedge clk);
    end
    op_valid = 1'b0; step_adv = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push(24'h0, 1'b0, 1'b1, "R1 after reset");
    @(negedge clk);
    run_op(8'h24, 4'h0, 1'b0, 0, "R3 after halt");

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule